// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block drives one frame-injection channel by following a chain of control blocks kept in memory. Each control block is a run of 64-bit words. The walker reads the words of one block through a read-request port and collects the link to the next block, an information word, and one length/address pair for each data segment. For every segment it presents the address, the length and the information field to a downstream data mover. When the last segment of a block has been accepted, it either follows the link or stops.

A chain ends on a link value of all ones. At that point the walker goes idle and pulses its done interrupt. A link with any of its low three bits set is misaligned and halts the channel with an alignment error. A chain that loops back on itself would otherwise run forever, so a per-run limit on the number of control blocks aborts the walk with a loop error. Software starts a run with a pulse and an aligned start address. It can request a stop, and the stop takes effect only at a segment boundary.

Both data interfaces use valid/ready handshakes. A request or a segment offer stays asserted, with stable payload, until the other side accepts it. Back-pressure on either side stalls the walk and loses nothing. Read responses carry only a valid signal. The walker keeps at most one read outstanding and takes the response in the cycle it arrives.

Top module: `dcb_chain_walker`

## Requirements
- R1: After reset the walker is idle. busy_o, rd_req_valid_o, blk_valid_o, done_irq_o, align_err_o and loop_err_o are all low.
- R2: For a control block at byte address A, the walker reads the word at A (link), then A+8 (information), then the status/pointer pairs at A+16, A+24 and so on. It issues one 64-bit read at a time. Each request holds a stable rd_addr_o until rd_req_ready_i is seen, and each control block costs exactly 2+2N reads.
- R3: Each segment is offered with blk_addr_o set to the low AW bits of its pointer word, blk_len_o set to the low LENW bits of its status word, and blk_info_o set to the low INFOW bits of the information word. The offer holds until blk_ready_i.
- R4: The segment count N per control block is blk_per_dcb_i, sampled at start. A value of 0 is taken as 1, and a value above MAXBLK is taken as MAXBLK.
- R5: A link of all ones ends the chain. No further read is made, busy_o falls, and done_irq_o is high for exactly one cycle.
- R6: Any other aligned link is followed, and the next control block is fetched from that address.
- R7: A start address or link that is not all ones and has any of bits [2:0] set raises align_err_o. The walker then halts with no further read and no interrupt. A misaligned start makes no read at all.
- R8: The number of control blocks in a run is limited to max_dcb_i (0 is taken as 1), sampled at start. If the block at the limit still carries a valid aligned link, loop_err_o rises and the walk halts with no further read. The end and alignment tests take precedence over the limit.
- R9: A stop_i pulse during a run is honoured only after the segment currently offered, or the next one to be offered, has been accepted. The walker then goes idle with no further read and no interrupt.
- R10: busy_o is high throughout a run. A start_i pulse while busy is ignored.
- R11: An accepted start clears align_err_o and loop_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | AW | Byte address of the first control block |
| stop_i | input | 1 | Stop request pulse |
| blk_per_dcb_i | input | BLKW | Segments per control block |
| max_dcb_i | input | CNTW | Control-block limit per run |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Read byte address (64-bit aligned) |
| rd_resp_valid_i | input | 1 | Read data valid |
| rd_resp_data_i | input | 64 | Read data word |
| blk_valid_o | output | 1 | Segment offer valid |
| blk_ready_i | input | 1 | Segment accepted by the data mover |
| blk_addr_o | output | AW | Segment address |
| blk_len_o | output | LENW | Segment length |
| blk_info_o | output | INFOW | Information field of the owning control block |
| busy_o | output | 1 | Walk in progress |
| done_irq_o | output | 1 | One-cycle pulse when the chain ends normally |
| align_err_o | output | 1 | Misaligned pointer seen |
| loop_err_o | output | 1 | Control-block limit reached |

## Verification
The assertions check the following on every cycle:
- Read requests and segment offers hold steady under back-pressure.
- Every read address is 64-bit aligned.
- The done pulse lasts one cycle and coincides with idle.
- An alignment error leaves the channel halted.
- The per-run control-block count never passes its limit.

Only the bench scenarios can show the rest. These cover the order of segments along a chain, the segment count after clamping, and which of end, misalignment or limit wins at a block boundary. They also show that a stop lands on a segment boundary, that a start during a run has no effect, and that the total number of reads matches the chain.

// File: rtl/dcbw_pkg.sv
package dcbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EMIT
  } walk_st_e;
endpackage

// File: rtl/dcbw_ptr_check.sv
module dcbw_ptr_check #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  output logic          is_end_o,
  output logic          is_misal_o
);
  always_comb begin
    is_end_o   = &ptr_i;
    is_misal_o = !is_end_o && (|ptr_i[2:0]);
  end
endmodule

// File: rtl/dcbw_loop_guard.sv
module dcbw_loop_guard #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic [CW-1:0] limit_i,
  input  logic          step_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CW'(1);
    end else if (clear_i) begin
      cnt_q <= '0;
      lim_q <= (limit_i == '0) ? CW'(1) : limit_i;
    end else if (step_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_comb last_o = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, lim_q};

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
endmodule

// File: rtl/dcb_chain_walker.sv
module dcb_chain_walker
  import dcbw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LENW   = 16,
  parameter int INFOW  = 16,
  parameter int MAXBLK = 4,
  parameter int CNTW   = 8,
  parameter int BLKW   = $clog2(MAXBLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic             stop_i,
  input  logic [BLKW-1:0]  blk_per_dcb_i,
  input  logic [CNTW-1:0]  max_dcb_i,
  output logic             rd_req_valid_o,
  input  logic             rd_req_ready_i,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_resp_valid_i,
  input  logic [63:0]      rd_resp_data_i,
  output logic             blk_valid_o,
  input  logic             blk_ready_i,
  output logic [AW-1:0]    blk_addr_o,
  output logic [LENW-1:0]  blk_len_o,
  output logic [INFOW-1:0] blk_info_o,
  output logic             busy_o,
  output logic             done_irq_o,
  output logic             align_err_o,
  output logic             loop_err_o
);
  localparam int NWORD = 2 + 2 * MAXBLK;
  localparam int IDXW  = $clog2(NWORD);

  walk_st_e          st_q;
  logic [AW-1:0]     base_q, next_q, ptr_q;
  logic [IDXW-1:0]   widx_q;
  logic [BLKW-1:0]   nblk_q, nblk_n;
  logic [LENW-1:0]   len_q;
  logic [INFOW-1:0]  info_q;
  logic              stop_q, irq_q, aerr_q, lerr_q;
  logic              nx_end, nx_misal, st_end, st_misal, at_last_dcb;
  logic              seg_last, accept_start, dcb_step, seg_taken;
  logic              unused_hi;

  assign unused_hi = ^rd_resp_data_i[63:AW];

  dcbw_ptr_check #(.AW(AW)) u_next_chk (
    .ptr_i(next_q), .is_end_o(nx_end), .is_misal_o(nx_misal));
  dcbw_ptr_check #(.AW(AW)) u_start_chk (
    .ptr_i(start_addr_i), .is_end_o(st_end), .is_misal_o(st_misal));

  always_comb begin
    if (blk_per_dcb_i == '0)                   nblk_n = BLKW'(1);
    else if (blk_per_dcb_i > BLKW'(MAXBLK))    nblk_n = BLKW'(MAXBLK);
    else                                       nblk_n = blk_per_dcb_i;
    seg_last     = (int'(widx_q) == 2 * int'(nblk_q) + 1);
    accept_start = (st_q == ST_IDLE) && start_i && !st_end && !st_misal;
    seg_taken    = (st_q == ST_EMIT) && blk_ready_i;
    dcb_step     = seg_taken && seg_last && !stop_q;
  end

  dcbw_loop_guard #(.CW(CNTW)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_start), .limit_i(max_dcb_i),
    .step_i(dcb_step), .last_o(at_last_dcb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      next_q <= '0;
      ptr_q  <= '0;
      widx_q <= '0;
      nblk_q <= BLKW'(1);
      len_q  <= '0;
      info_q <= '0;
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
      aerr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (st_q != ST_IDLE && stop_i) stop_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (st_end || st_misal) begin
            aerr_q <= 1'b1;
            lerr_q <= 1'b0;
          end else begin
            base_q <= start_addr_i;
            widx_q <= '0;
            nblk_q <= nblk_n;
            stop_q <= 1'b0;
            aerr_q <= 1'b0;
            lerr_q <= 1'b0;
            st_q   <= ST_REQ;
          end
        end
        ST_REQ: if (rd_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rd_resp_valid_i) begin
          if (widx_q == IDXW'(0))      next_q <= rd_resp_data_i[AW-1:0];
          else if (widx_q == IDXW'(1)) info_q <= rd_resp_data_i[INFOW-1:0];
          else if (!widx_q[0])         len_q  <= rd_resp_data_i[LENW-1:0];
          else                         ptr_q  <= rd_resp_data_i[AW-1:0];
          if (widx_q >= IDXW'(3) && widx_q[0]) st_q <= ST_EMIT;
          else begin
            widx_q <= widx_q + IDXW'(1);
            st_q   <= ST_REQ;
          end
        end
        ST_EMIT: if (blk_ready_i) begin
          if (stop_q) st_q <= ST_IDLE;
          else if (!seg_last) begin
            widx_q <= widx_q + IDXW'(1);
            st_q   <= ST_REQ;
          end else if (nx_end) begin
            irq_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (nx_misal) begin
            aerr_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (at_last_dcb) begin
            lerr_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            base_q <= next_q;
            widx_q <= '0;
            st_q   <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req_valid_o = (st_q == ST_REQ);
    rd_addr_o      = base_q + AW'({widx_q, 3'b000});
    blk_valid_o    = (st_q == ST_EMIT);
    blk_addr_o     = ptr_q;
    blk_len_o      = len_q;
    blk_info_o     = info_q;
    busy_o         = (st_q != ST_IDLE);
    done_irq_o     = irq_q;
    align_err_o    = aerr_q;
    loop_err_o     = lerr_q;
  end

  // R2
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_addr_o));
  // R2
  rd_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o |-> rd_addr_o[2:0] == 3'b000);
  // R3
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid_o && !blk_ready_i |=> blk_valid_o && $stable(blk_addr_o)
      && $stable(blk_len_o) && $stable(blk_info_o));
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |=> !done_irq_o);
  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |-> !busy_o && !rd_req_valid_o);
  // R7
  align_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_err_o) |-> !busy_o && !done_irq_o);
endmodule

// File: tb/test_dcb_chain_walker.sv
module test_dcb_chain_walker;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, stop, rd_req_valid, rd_req_ready, rsp_valid;
  logic [31:0] saddr, rd_addr, blk_addr;
  logic [2:0]  nbk;
  logic [7:0]  maxd;
  logic [63:0] rsp_data;
  logic        blk_valid, blk_ready, busy, done_irq, align_err, loop_err;
  logic [15:0] blk_len, blk_info;

  dcb_chain_walker i_dcb_chain_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(saddr),
    .stop_i(stop), .blk_per_dcb_i(nbk), .max_dcb_i(maxd),
    .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready),
    .rd_addr_o(rd_addr), .rd_resp_valid_i(rsp_valid), .rd_resp_data_i(rsp_data),
    .blk_valid_o(blk_valid), .blk_ready_i(blk_ready), .blk_addr_o(blk_addr),
    .blk_len_o(blk_len), .blk_info_o(blk_info), .busy_o(busy),
    .done_irq_o(done_irq), .align_err_o(align_err), .loop_err_o(loop_err));

  logic [63:0] mem [0:127];
  logic [31:0] tick = 0;
  logic        clr, sink_hold;
  int          gcnt, rd_cnt, irq_cnt;
  logic [31:0] g_addr [0:63];
  logic [15:0] g_len  [0:63];
  logic [15:0] g_info [0:63];
  int          tests, fails;

  assign rd_req_ready = (tick[2:0] != 3'd5);
  assign blk_ready    = !sink_hold && (tick[1:0] != 2'd3);

  always @(posedge clk) begin
    tick      <= tick + 1;
    rsp_valid <= rd_req_valid && rd_req_ready;
    if (rd_req_valid && rd_req_ready) rsp_data <= mem[rd_addr[9:3]];
    if (clr) begin
      gcnt <= 0; rd_cnt <= 0; irq_cnt <= 0;
    end else begin
      if (rd_req_valid && rd_req_ready) rd_cnt <= rd_cnt + 1;
      if (blk_valid && blk_ready) begin
        if (gcnt < 64) begin
          g_addr[gcnt] <= blk_addr; g_len[gcnt] <= blk_len; g_info[gcnt] <= blk_info;
        end
        gcnt <= gcnt + 1;
      end
      if (done_irq) irq_cnt <= irq_cnt + 1;
    end
  end

  // vector: start[29:14] blocks[13:10] limit[9:2] result[1:0] (0 done, 1 align, 2 loop)
  localparam logic [29:0] VEC [0:8] = '{
    {16'd0,   4'd2, 8'd8, 2'd0},
    {16'd0,   4'd4, 8'd8, 2'd0},
    {16'd240, 4'd1, 8'd8, 2'd0},
    {16'd320, 4'd3, 8'd8, 2'd1},
    {16'd480, 4'd2, 8'd5, 2'd2},
    {16'd0,   4'd2, 8'd2, 2'd2},
    {16'd240, 4'd0, 8'd8, 2'd0},
    {16'd640, 4'd7, 8'd8, 2'd0},
    {16'd0,   4'd1, 8'd3, 2'd0}
  };

  int          e_n, e_reads, e_res;
  logic [31:0] e_addr [0:63];
  logic [15:0] e_len  [0:63];
  logic [15:0] e_info [0:63];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mk(input int d, input logic [31:0] nxt);
    int w = d * 10;
    mem[w]   = {32'hA5A5_0000 + 32'(d), nxt};
    mem[w+1] = {48'hBEEF_0000_0000, 16'(16'h100 + d)};
    for (int k = 0; k < 4; k++) begin
      mem[w+2+2*k] = {48'hFFFF_0000_0000, 16'(d * 16 + k + 1)};
      mem[w+3+2*k] = {32'h7777_0000, 32'h2000_0000 + 32'(d * 256 + k * 16)};
    end
  endtask

  task automatic model(input int sa, input int nb, input int md);
    int n = (nb == 0) ? 1 : (nb > 4 ? 4 : nb);
    int m = (md < 1) ? 1 : md;
    int a = sa;
    int cnt = 0;
    logic [31:0] nx;
    e_n = 0; e_reads = 0; e_res = 0;
    for (int guard = 0; guard < 64; guard++) begin
      int w = a / 8;
      e_reads += 2 + 2 * n;
      for (int k = 0; k < n; k++) begin
        e_addr[e_n] = mem[w+3+2*k][31:0];
        e_len[e_n]  = mem[w+2+2*k][15:0];
        e_info[e_n] = mem[w+1][15:0];
        e_n++;
      end
      cnt++;
      nx = mem[w][31:0];
      if (nx == 32'hFFFF_FFFF) begin e_res = 0; break; end
      if (nx[2:0] != 3'b000)   begin e_res = 1; break; end
      if (cnt >= m)            begin e_res = 2; break; end
      a = int'(nx);
    end
  endtask

  task automatic launch(input logic [31:0] a, input logic [2:0] nb, input logic [7:0] md);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1; saddr = a; nbk = nb; maxd = md;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(1'b0, "R10 hang", n, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; start = 0; stop = 0; saddr = 0; nbk = 0; maxd = 0;
    clr = 1'b1; sink_hold = 1'b0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mk(0, 32'd80); mk(1, 32'd160); mk(2, 32'hFFFF_FFFF); mk(3, 32'hFFFF_FFFF);
    mk(4, 32'd404); mk(6, 32'd560); mk(7, 32'd480); mk(8, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_req_valid && !blk_valid, "R1 idle", busy, 0);
    chk(!done_irq && !align_err && !loop_err, "R1 flags", {done_irq, align_err, loop_err}, 0);

    for (int v = 0; v < 9; v++) begin
      int sa = int'(VEC[v][29:14]);
      int nb = int'(VEC[v][13:10]);
      int md = int'(VEC[v][9:2]);
      int rs = int'(VEC[v][1:0]);
      int mism = 0;
      model(sa, nb, md);
      launch(32'(sa), 3'(nb), 8'(md));
      wait_idle();
      chk(irq_cnt == ((rs == 0) ? 1 : 0), "R5 done pulse", irq_cnt, (rs == 0) ? 1 : 0);
      chk(align_err == (rs == 1), "R7 align flag", align_err, rs == 1);
      chk(loop_err == (rs == 2), "R8 loop flag", loop_err, rs == 2);
      chk(gcnt == e_n, "R4 R6 segment count", gcnt, e_n);
      for (int i = 0; i < e_n && i < 64; i++)
        if (g_addr[i] != e_addr[i] || g_len[i] != e_len[i] || g_info[i] != e_info[i]) mism++;
      chk(mism == 0, "R3 segment fields", mism, 0);
      chk(rd_cnt == e_reads, "R2 read count", rd_cnt, e_reads);
    end

    // R7 misaligned start: no read, error, idle
    launch(32'h0000_0044, 3'd2, 8'd8);
    wait_idle();
    chk(align_err && !busy, "R7 bad start", align_err, 1);
    chk(rd_cnt == 0, "R7 no read on bad start", rd_cnt, 0);

    // R11 accepted start clears error
    launch(32'd240, 3'd1, 8'd8);
    chk(!align_err && busy, "R11 error cleared", align_err, 0);
    wait_idle();

    // R10 busy and start ignored while busy
    launch(32'd0, 3'd2, 8'd8);
    chk(busy == 1'b1, "R10 busy during run", busy, 1);
    start = 1'b1; saddr = 32'd240; nbk = 3'd1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk(gcnt == 6 && irq_cnt == 1, "R10 restart ignored", gcnt, 6);

    // R9 stop honoured after the offered segment
    sink_hold = 1'b1;
    launch(32'd0, 3'd2, 8'd8);
    for (int n = 0; n < 200 && !blk_valid; n++) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    sink_hold = 1'b0;
    wait_idle();
    chk(gcnt == 1, "R9 one segment before stop", gcnt, 1);
    chk(rd_cnt == 4 && irq_cnt == 0 && !busy, "R9 no further reads", rd_cnt, 4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule